// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by walking a two-level page table stored in memory. A requester offers an address with a valid/ready handshake. The walker captures the address together with the root table page number. It then issues two dependent reads on a simple memory port, one read and one response at a time.

The first read fetches the outer-table entry. That entry names the page holding the inner table. The second read fetches the inner entry, which holds the physical frame number. An invalid entry at either level ends the walk early with a fault. The fault reports which level held the invalid entry. The walker serves a single translation at a time and returns to idle after each response.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The offset is vaddr[11:0], the inner index is vaddr[21:12] and the outer index is vaddr[31:22].
- R3: On the cycle after a request is accepted, `mem_req` is 1 for one cycle with `mem_addr` = {root_ppn, 12'h000} + 4 * outer index.
- R4: A table entry is 32 bits. Bit 0 is the valid flag (1 = valid) and bits 31:12 are a page number; bits 11:1 are ignored.
- R5: If the outer entry is invalid, no second read is made. `rsp_valid` rises the cycle after `mem_rvalid`, with `rsp_fault`=1, `rsp_level`=0 and `rsp_paddr`=0.
- R6: If the outer entry is valid, the cycle after its `mem_rvalid` brings a one-cycle `mem_req` with `mem_addr` = {outer[31:12], 12'h000} + 4 * inner index.
- R7: If the inner entry is invalid, `rsp_valid` rises the cycle after its `mem_rvalid`, with `rsp_fault`=1, `rsp_level`=1 and `rsp_paddr`=0.
- R8: If the inner entry is valid, `rsp_valid` rises the cycle after its `mem_rvalid`, with `rsp_fault`=0 and `rsp_paddr` = {inner[31:12], vaddr[11:0]}.
- R9: `rsp_valid` lasts exactly one cycle, and `req_ready` is 1 again on the next cycle.
- R10: From acceptance until the response, `req_ready` is 0. Changes on `req_valid`, `req_vaddr` and `root_ppn` during this time do not alter the walk or its result.
- R11: Memory data may arrive any number of cycles after a read. `mem_req` is never held or repeated while waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_ppn | input | 20 | Page number of the outer table, sampled at acceptance |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned table entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_level | output | 1 | Level of the invalid entry (0 outer, 1 inner) |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
Acceptance happens at clock edge 0. The first read strobe follows one cycle later. An outer fault response appears 2+L1 edges after acceptance, where L1 is the extra wait of the outer read. A full walk, or an inner fault, responds after 4+L1+L2 edges. The bench's memory model inserts L1 and L2 itself, so it can predict the exact negative edge at which `rsp_valid` must first appear. It compares the measured cycle count against that prediction. It also checks each read address when the strobe is seen, and it samples the ready and strobe levels one cycle after the response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int VA_W      = OFF_W + 2 * IDX_W;
  localparam int PN_W      = VA_W - OFF_W;
  localparam int PTE_W     = 32;
  localparam int PTE_SHIFT = 2;
  localparam int VALID_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_OUT, ST_WT_OUT, ST_RD_IN, ST_WT_IN, ST_DONE, ST_FAULT
  } walk_st_t;

  function automatic logic [IDX_W-1:0] outer_idx(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] inner_idx(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [VA_W-1:0] entry_addr(input logic [PN_W-1:0] tbl,
                                                 input logic [IDX_W-1:0] idx);
    logic [VA_W-1:0] off;
    off = VA_W'(idx) << PTE_SHIFT;
    return {tbl, {OFF_W{1'b0}}} + off;
  endfunction

  function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
    return pte[VALID_BIT];
  endfunction

  function automatic logic [PN_W-1:0] pte_pn(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: PN_W];
  endfunction
endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  output logic             pte_valid,
  output logic [PN_W-1:0]  pte_base
);
  assign pte_valid = pte_ok(pte);
  assign pte_base  = pte_pn(pte);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic            inner_lvl,
  input  logic [VA_W-1:0] va,
  input  logic [PN_W-1:0] root_pn,
  input  logic [PN_W-1:0] tbl_pn,
  output logic [VA_W-1:0] addr
);
  always_comb begin
    if (inner_lvl) addr = entry_addr(tbl_pn, inner_idx(va));
    else           addr = entry_addr(root_pn, outer_idx(va));
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PN_W-1:0] root_pn,
  input  logic            mem_rvalid,
  input  logic            pte_valid,
  input  logic [PN_W-1:0] pte_base,
  output logic            req_ready,
  output logic            mem_req,
  output logic            inner_lvl,
  output logic [VA_W-1:0] va_q,
  output logic [PN_W-1:0] root_q,
  output logic [PN_W-1:0] tbl_q,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_level,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            ev_accept,
  output logic            ev_out_ok,
  output logic            ev_out_bad,
  output logic            ev_in_ok,
  output logic            ev_in_bad
);
  walk_st_t        st, st_nx;
  logic [PN_W-1:0] frame_q;
  logic            lvl_q;

  assign ev_accept  = (st == ST_IDLE) && req_valid;
  assign ev_out_ok  = (st == ST_WT_OUT) && mem_rvalid && pte_valid;
  assign ev_out_bad = (st == ST_WT_OUT) && mem_rvalid && !pte_valid;
  assign ev_in_ok   = (st == ST_WT_IN) && mem_rvalid && pte_valid;
  assign ev_in_bad  = (st == ST_WT_IN) && mem_rvalid && !pte_valid;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (ev_accept) st_nx = ST_RD_OUT;
      ST_RD_OUT: st_nx = ST_WT_OUT;
      ST_WT_OUT: begin
        if (ev_out_ok)       st_nx = ST_RD_IN;
        else if (ev_out_bad) st_nx = ST_FAULT;
      end
      ST_RD_IN:  st_nx = ST_WT_IN;
      ST_WT_IN: begin
        if (ev_in_ok)       st_nx = ST_DONE;
        else if (ev_in_bad) st_nx = ST_FAULT;
      end
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      frame_q <= '0;
      lvl_q   <= 1'b0;
    end else begin
      st <= st_nx;
      if (ev_accept) begin
        va_q   <= req_vaddr;
        root_q <= root_pn;
      end
      if (ev_out_ok)  tbl_q   <= pte_base;
      if (ev_out_bad) lvl_q   <= 1'b0;
      if (ev_in_ok)   frame_q <= pte_base;
      if (ev_in_bad)  lvl_q   <= 1'b1;
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_RD_OUT) || (st == ST_RD_IN);
  assign inner_lvl = (st == ST_RD_IN) || (st == ST_WT_IN);
  assign rsp_valid = (st == ST_DONE) || (st == ST_FAULT);
  assign rsp_fault = (st == ST_FAULT);
  assign rsp_level = (st == ST_FAULT) && lvl_q;
  assign rsp_paddr = (st == ST_DONE) ? {frame_q, va_q[OFF_W-1:0]} : '0;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PN_W-1:0]  root_ppn,
  output logic             mem_req,
  output logic [VA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_level,
  output logic [VA_W-1:0]  rsp_paddr
);
  logic            pte_valid;
  logic [PN_W-1:0] pte_base;
  logic            inner_lvl;
  logic [VA_W-1:0] va_q;
  logic [PN_W-1:0] root_q;
  logic [PN_W-1:0] tbl_q;
  logic            ev_accept, ev_out_ok, ev_out_bad, ev_in_ok, ev_in_bad;

  ptw_pte_check u_pte (
    .pte       (mem_rdata),
    .pte_valid (pte_valid),
    .pte_base  (pte_base)
  );

  ptw_addr_gen u_agen (
    .inner_lvl (inner_lvl),
    .va        (va_q),
    .root_pn   (root_q),
    .tbl_pn    (tbl_q),
    .addr      (mem_addr)
  );

  ptw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .root_pn    (root_ppn),
    .mem_rvalid (mem_rvalid),
    .pte_valid  (pte_valid),
    .pte_base   (pte_base),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .inner_lvl  (inner_lvl),
    .va_q       (va_q),
    .root_q     (root_q),
    .tbl_q      (tbl_q),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_level  (rsp_level),
    .rsp_paddr  (rsp_paddr),
    .ev_accept  (ev_accept),
    .ev_out_ok  (ev_out_ok),
    .ev_out_bad (ev_out_bad),
    .ev_in_ok   (ev_in_ok),
    .ev_in_bad  (ev_in_bad)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic mem_req,
  input logic rsp_valid,
  input logic rsp_fault,
  input logic rsp_level,
  input logic ev_accept,
  input logic ev_out_ok,
  input logic ev_out_bad,
  input logic ev_in_ok,
  input logic ev_in_bad
);
  // R3
  accept_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_req);
  // R11
  read_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R6
  outer_then_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out_ok |=> mem_req);
  // R5
  outer_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out_bad |=> (rsp_valid && rsp_fault && !rsp_level && !mem_req));
  // R7
  inner_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_bad |=> (rsp_valid && rsp_fault && rsp_level));
  // R8
  inner_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_ok |=> (rsp_valid && !rsp_fault));
  // R9
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_level  (rsp_level),
  .ev_accept  (ev_accept),
  .ev_out_ok  (ev_out_ok),
  .ev_out_bad (ev_out_bad),
  .ev_in_ok   (ev_in_ok),
  .ev_in_bad  (ev_in_bad)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [19:0] root_ppn = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_level;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int failures = 0;
  int rd_idx = 0;
  int lat1 = 0, lat2 = 0;
  logic [31:0] exp_addr [2];
  bit done = 0;
  int n_ofault = 0, n_ifault = 0, n_ok = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_ppn(root_ppn), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_paddr(rsp_paddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory image: entry content derived from its address by mixing
  function automatic logic [31:0] mem_img(input logic [31:0] a);
    logic [31:0] x;
    x = a * 32'h9E37_79B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return {x[31:1], (x[6:4] != 3'd0)};
  endfunction

  // R2, R3, R6 entry address from page number and index
  function automatic logic [31:0] ent_at(input logic [19:0] pn, input int idx);
    return {pn, 12'h000} + 32'(idx * 4);
  endfunction

  // kind: 0 outer fault, 1 inner fault, 2 full translation
  function automatic int walk_kind(input logic [31:0] va, input logic [19:0] root);
    logic [31:0] e1, e2;
    e1 = mem_img(ent_at(root, int'(va >> 22)));
    if (!e1[0]) return 0;
    e2 = mem_img(ent_at(e1[31:12], int'((va >> 12) & 32'h3FF)));
    return e2[0] ? 2 : 1;
  endfunction

  // memory responder
  initial begin
    @(negedge clk);
    forever begin
      while (!mem_req) @(negedge clk);
      if (rd_idx < 2)
        chk(mem_addr == exp_addr[rd_idx], rd_idx == 0 ? "R3 outer addr" : "R6 inner addr",
            mem_addr, exp_addr[rd_idx]);
      else
        chk(1'b0, "R5 unexpected read", mem_addr, 32'h0);
      begin
        logic [31:0] a;
        int l;
        a = mem_addr;
        l = (rd_idx == 0) ? lat1 : lat2;
        rd_idx++;
        @(negedge clk);
        // R11 no repeated strobe while waiting
        chk(!mem_req, "R11 strobe held", {31'b0, mem_req}, 32'h0);
        repeat (l) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem_img(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = $urandom;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] root,
                      input int l1, input int l2, input bit poke);
    logic [31:0] e1, e2, exp_pa;
    int kind, exp_n, n, exp_rd;
    e1 = mem_img(ent_at(root, int'(va >> 22)));
    exp_addr[0] = ent_at(root, int'(va >> 22));
    exp_addr[1] = ent_at(e1[31:12], int'((va >> 12) & 32'h3FF));
    e2 = mem_img(exp_addr[1]);
    kind = walk_kind(va, root);
    exp_n  = (kind == 0) ? 3 + l1 : 5 + l1 + l2;
    exp_rd = (kind == 0) ? 1 : 2;
    exp_pa = (kind == 2) ? {e2[31:12], va[11:0]} : 32'h0;
    lat1 = l1; lat2 = l2; rd_idx = 0;
    req_valid = 1'b1; req_vaddr = va; root_ppn = root;
    @(negedge clk);
    n = 1;
    // R10 busy once accepted; inputs changed during walk must be ignored
    chk(!req_ready, "R10 ready while busy", {31'b0, req_ready}, 32'h0);
    if (poke) begin req_vaddr = ~va; root_ppn = ~root; end
    else req_valid = 1'b0;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    chk(n == exp_n, "R9/R11 response cycle", 32'(n), 32'(exp_n));
    if (kind == 0) begin
      n_ofault++;
      chk(rsp_fault && !rsp_level, "R5 outer fault", {30'b0, rsp_fault, rsp_level}, 32'h2);
    end else if (kind == 1) begin
      n_ifault++;
      chk(rsp_fault && rsp_level, "R7 inner fault", {30'b0, rsp_fault, rsp_level}, 32'h3);
    end else begin
      n_ok++;
      chk(!rsp_fault, "R8 no fault", {31'b0, rsp_fault}, 32'h0);
    end
    chk(rsp_paddr == exp_pa, poke ? "R10 paddr under poke" : "R8 paddr", rsp_paddr, exp_pa);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 one-cycle strobe", {30'b0, rsp_valid, req_ready}, 32'h1);
    chk(rd_idx == exp_rd, "R5 read count", 32'(rd_idx), 32'(exp_rd));
  endtask

  task automatic find_walk(input int kind, input logic [19:0] root, input int l1,
                           input int l2, input bit poke);
    logic [31:0] va;
    va = $urandom;
    for (int i = 0; i < 20000 && walk_kind(va, root) != kind; i++) va = $urandom;
    walk(va, root, l1, l2, poke);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 after reset",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    // directed corners: R2 index extremes, R4 valid bit, long waits
    walk(32'h0000_0000, 20'h00000, 0, 0, 0);
    walk(32'hFFFF_FFFF, 20'hFFFFF, 0, 0, 0);
    find_walk(0, 20'h12345, 0, 0, 0);
    find_walk(0, 20'h00ABC, 5, 0, 1);
    find_walk(1, 20'h12345, 0, 0, 0);
    find_walk(1, 20'h7F00F, 2, 6, 1);
    find_walk(2, 20'h12345, 0, 0, 0);
    find_walk(2, 20'h3C3C3, 7, 3, 1);
    find_walk(2, 20'hFFFFF, 0, 0, 0);
    // random mix
    for (int i = 0; i < 80; i++)
      walk($urandom, 20'($urandom), int'($urandom % 4), int'($urandom % 4), bit'($urandom % 2));
    chk(n_ofault > 0 && n_ifault > 0 && n_ok > 0, "R4 all outcomes seen",
        32'(n_ofault * 0 + n_ifault), 32'(n_ok));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule